// File: doc/BRIEF.md
# Chainable Vectored Interrupt Controller

The block collects eight interrupt requests for a microprocessor: five internal sources, taken as synchronous levels, and three external pins. Each external pin has its own trigger mode. In edge mode a rising edge is caught after a two-flop synchronizer and held in a sticky pending bit. In level mode the pin counts as pending for as long as it is high. A per-source enable mask gates every request. The enabled pending source with the lowest index drives the interrupt request line. During an acknowledge cycle it supplies an 8-bit vector, made of a programmable 5-bit base followed by the 3-bit source index.

Several controllers can share one acknowledge. They are chained through a priority-in and priority-out pair. A controller answers an acknowledge only when its priority-in is high and it has an enabled pending source. Otherwise it forwards priority-in to priority-out, so exactly one chip in the chain drives a vector. The host reaches the registers through a 16-bit write bus and a 16-bit read bus, with a 4-bit address.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the mask, the trigger modes, the vector base and all pending bits read 0, irq_o is 0 and pri_o equals pri_i.
- R2: Register map: address 0 holds the mask in bits 7:0 (bit n enables source n); address 1 holds the trigger modes in bits 2:0 (bit j = 1 selects edge mode for source 5+j); address 2 holds the vector base in bits 4:0; address 3 reads the pending bits before masking, in bits 7:0.
- R3: Every other address reads 0, and a write to it changes no register.
- R4: irq_o is high exactly when some source is both pending and enabled in the mask. Sources are numbered 0 to 4 for int_src_i[4:0] and 5 to 7 for ext_irq_i[2:0].
- R5: A level-mode external source is pending while its pin is high, with at most three clock cycles of synchronizer delay, and stops being pending once the pin has been low for three cycles.
- R6: An edge-mode external source becomes pending within three cycles of a rising edge on its pin. It stays pending after the pin falls.
- R7: Writing 1 to bit 5+j of address 3 clears the edge pending bit of source 5+j. Writing 0 to that bit leaves it set.
- R8: When several enabled sources are pending, the lowest source index wins.
- R9: While inta_i and pri_i are both high and some enabled source is pending, vec_oe_o is 1 and vec_o equals {base, winning index}.
- R10: An acknowledge won by an edge-mode source clears that source's pending bit. An acknowledge does not clear a level-mode or internal source.
- R11: pri_o is 0 while any enabled source is pending and equals pri_i otherwise. With pri_i low, an acknowledge drives no vector and clears no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| int_src_i | input | 5 | Internal level requests, sources 0 to 4 |
| ext_irq_i | input | 3 | Asynchronous external requests, sources 5 to 7 |
| irq_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Interrupt acknowledge |
| pri_i | input | 1 | Chain priority in |
| pri_o | output | 1 | Chain priority out |
| vec_o | output | 8 | Vector, valid while vec_oe_o is high |
| vec_oe_o | output | 1 | This chip is answering the acknowledge |

## Verification
The bench targets several corner cases, each with a known failure if the design gets it wrong:
- A masked source that still pends would raise irq_o or steal the vector.
- A reversed priority encoder would return index 4 instead of 2.
- A pending bit that cleared itself when the pin fell would lose edge-mode requests.
- A write-one-clear that acted on zeros would drop pending edges.
- A chip that answered with pri_i low, or cleared its pending bit on an acknowledge it did not win, would corrupt the chain.
- An acknowledge that cleared level or internal sources would hide requests that are still asserted.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_MASK = 4'h0;
  localparam logic [ADDR_W-1:0] A_MODE = 4'h1;
  localparam logic [ADDR_W-1:0] A_BASE = 4'h2;
  localparam logic [ADDR_W-1:0] A_PEND = 4'h3;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int N_INT  = 5,
  parameter int N_EXT  = 3,
  parameter int BASE_W = 5,
  localparam int N_SRC = N_INT + N_EXT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [N_SRC-1:0]  pend_i,
  output logic [N_SRC-1:0]  mask_o,
  output logic [N_EXT-1:0]  mode_o,
  output logic [BASE_W-1:0] base_o,
  output logic [N_EXT-1:0]  w1c_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      mode_o <= '0;
      base_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_MASK:  mask_o <= wdata_i[N_SRC-1:0];
        A_MODE:  mode_o <= wdata_i[N_EXT-1:0];
        A_BASE:  base_o <= wdata_i[BASE_W-1:0];
        default: ;
      endcase
    end
  end

  assign w1c_o = (we_i && addr_i == A_PEND) ? wdata_i[N_INT +: N_EXT] : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MASK:  rdata_o[N_SRC-1:0]  = mask_o;
      A_MODE:  rdata_o[N_EXT-1:0]  = mode_o;
      A_BASE:  rdata_o[BASE_W-1:0] = base_o;
      A_PEND:  rdata_o[N_SRC-1:0]  = pend_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_ext.sv
module irq_ext (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o
);
  logic s1_q, s2_q, s3_q, edge_q;
  logic rise;

  assign rise = s2_q & ~s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      // a new edge wins over a same-cycle clear
      if (!edge_mode_i)  edge_q <= 1'b0;
      else if (rise)     edge_q <= 1'b1;
      else if (clr_i)    edge_q <= 1'b0;
    end
  end

  assign pend_o = edge_mode_i ? edge_q : s2_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_INT = 5,
  parameter int N_EXT = 3,
  parameter int VEC_W = 8,
  localparam int N_SRC  = N_INT + N_EXT,
  localparam int IDX_W  = $clog2(N_SRC),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_INT-1:0]  int_src_i,
  input  logic [N_EXT-1:0]  ext_irq_i,
  output logic              irq_o,
  input  logic              inta_i,
  input  logic              pri_i,
  output logic              pri_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_oe_o
);
  logic [N_SRC-1:0]  mask_q, pend_all, active;
  logic [N_EXT-1:0]  mode_q, w1c, ext_pend;
  logic [BASE_W-1:0] base_q;
  logic [IDX_W-1:0]  win_idx;
  logic              any_act, ack_win;

  irq_regs #(.N_INT(N_INT), .N_EXT(N_EXT), .BASE_W(BASE_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .we_i(bus_we_i),
    .pend_i(pend_all), .mask_o(mask_q), .mode_o(mode_q), .base_o(base_q),
    .w1c_o(w1c), .rdata_o(bus_rdata_o)
  );

  for (genvar j = 0; j < N_EXT; j++) begin : g_ext
    logic ack_clr;
    assign ack_clr = ack_win && (win_idx == IDX_W'(N_INT + j));
    irq_ext u_ext (
      .clk_i, .rst_ni,
      .pin_i(ext_irq_i[j]), .edge_mode_i(mode_q[j]),
      .clr_i(w1c[j] | ack_clr), .pend_o(ext_pend[j])
    );
  end

  assign pend_all = {ext_pend, int_src_i};
  assign active   = pend_all & mask_q;

  irq_prio #(.N_SRC(N_SRC)) u_prio (.req_i(active), .any_o(any_act), .idx_o(win_idx));

  assign ack_win  = inta_i & pri_i & any_act;
  assign irq_o    = any_act;
  assign vec_oe_o = ack_win;
  assign vec_o    = ack_win ? {base_q, win_idx} : '0;
  assign pri_o    = pri_i & ~any_act;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             inta_i,
  input logic             pri_i,
  input logic             pri_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_oe_o,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] pend_all
);
  // R9
  vec_oe_only_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> (inta_i && pri_i));
  // R11
  pri_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_o |-> pri_i);
  // R11
  single_answer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_oe_o && pri_o));
  // R4
  no_vec_without_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> !vec_oe_o);
  // R8
  vec_src_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> (mask_q[vec_o[IDX_W-1:0]] && pend_all[vec_o[IDX_W-1:0]]));
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk_i, .rst_ni, .irq_o, .inta_i, .pri_i, .pri_o, .vec_o, .vec_oe_o,
  .mask_q, .pend_all
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        we = 1'b0;
  logic [4:0]  int_src = '0;
  logic [2:0]  ext = '0;
  logic        irq, inta = 1'b0, pri_in = 1'b1, pri_out, vec_oe;
  logic [7:0]  vec;
  int n_chk = 0, n_fail = 0;
  bit  done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_rdata_o(rdata), .int_src_i(int_src), .ext_irq_i(ext),
    .irq_o(irq), .inta_i(inta), .pri_i(pri_in), .pri_o(pri_out),
    .vec_o(vec), .vec_oe_o(vec_oe)
  );

  // {mask[26:19], int_src[18:14], base[13:9], vec[8:1], irq[0]}
  localparam logic [26:0] TBL [6] = '{
    {8'hFF, 5'b10100, 5'h03, 8'h1A, 1'b1},
    {8'hFB, 5'b10100, 5'h03, 8'h1C, 1'b1},
    {8'h00, 5'b11111, 5'h1F, 8'h00, 1'b0},
    {8'h10, 5'b10000, 5'h1F, 8'hFC, 1'b1},
    {8'hFF, 5'b00001, 5'h10, 8'h80, 1'b1},
    {8'h02, 5'b00011, 5'h00, 8'h01, 1'b1}
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  // one-cycle acknowledge, outputs sampled mid-cycle
  task automatic ack(logic p, output logic oe, output logic [7:0] v, output logic po);
    @(negedge clk); inta = 1'b1; pri_in = p;
    #1 oe = vec_oe; v = vec; po = pri_out;
    @(negedge clk); inta = 1'b0; pri_in = 1'b1;
  endtask

  initial begin
    logic [15:0] d;
    logic oe, po;
    logic [7:0] v;
    #(3*CLK_P) rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a), d); chk("R1 reg", d, 16'h0);
    end
    chk("R1 irq", {15'b0, irq}, 16'h0);
    pri_in = 1'b0; #1 chk("R1 pri_o low", {15'b0, pri_out}, 16'h0);
    pri_in = 1'b1; #1 chk("R1 pri_o high", {15'b0, pri_out}, 16'h1);

    // table: R4 masking, R8 priority, R9 vector
    for (int i = 0; i < 6; i++) begin
      wr(4'h0, {8'h0, TBL[i][26:19]});
      wr(4'h2, {11'h0, TBL[i][13:9]});
      int_src = TBL[i][18:14];
      @(negedge clk);
      chk("R4 irq", {15'b0, irq}, {15'b0, TBL[i][0]});
      ack(1'b1, oe, v, po);
      chk("R9 vec_oe", {15'b0, oe}, {15'b0, TBL[i][0]});
      chk("R8 R9 vec", {8'h0, v}, {8'h0, TBL[i][8:1]});
      chk("R11 pri_o", {15'b0, po}, {15'b0, ~TBL[i][0]});
    end
    int_src = '0;

    // R2 readback
    wr(4'h0, 16'hFFFF); wr(4'h1, 16'hFFFF); wr(4'h2, 16'hFFFF);
    rd(4'h0, d); chk("R2 mask", d, 16'h00FF);
    rd(4'h1, d); chk("R2 mode", d, 16'h0007);
    rd(4'h2, d); chk("R2 base", d, 16'h001F);
    // R3 unmapped address
    wr(4'h5, 16'hFFFF); rd(4'h5, d); chk("R3 read", d, 16'h0);
    wr(4'h0, 16'h00AA); wr(4'h7, 16'h0000);
    rd(4'h0, d); chk("R3 mask kept", d, 16'h00AA);

    // R5 level mode on source 5
    wr(4'h1, 16'h0); wr(4'h0, 16'h00FF); wr(4'h2, 16'h0002);
    @(negedge clk); ext[0] = 1'b1; wait_cyc(3);
    rd(4'h3, d); chk("R5 level pend", d, 16'h0020);
    chk("R5 irq", {15'b0, irq}, 16'h1);
    ack(1'b1, oe, v, po); chk("R9 ext vec", {8'h0, v}, 16'h0015);
    rd(4'h3, d); chk("R10 level kept", d, 16'h0020);
    ext[0] = 1'b0; wait_cyc(3);
    rd(4'h3, d); chk("R5 level gone", d, 16'h0);

    // R6 edge mode on source 5
    wr(4'h1, 16'h0001);
    @(negedge clk); ext[0] = 1'b1; wait_cyc(3);
    @(negedge clk); ext[0] = 1'b0; wait_cyc(3);
    rd(4'h3, d); chk("R6 edge sticky", d, 16'h0020);
    wr(4'h3, 16'h00DF); rd(4'h3, d); chk("R7 write 0 keeps", d, 16'h0020);
    wr(4'h3, 16'h0020); rd(4'h3, d); chk("R7 w1c", d, 16'h0);

    // R11 chain blocked, R10 ack clear, R8 internal wins
    @(negedge clk); ext[0] = 1'b1; wait_cyc(3);
    @(negedge clk); ext[0] = 1'b0; wait_cyc(2);
    ack(1'b0, oe, v, po);
    chk("R11 no vec oe", {15'b0, oe}, 16'h0);
    chk("R11 pri_o blocked", {15'b0, po}, 16'h0);
    rd(4'h3, d); chk("R11 pend kept", d, 16'h0020);
    int_src = 5'b10000;
    ack(1'b1, oe, v, po); chk("R8 internal first", {8'h0, v}, 16'h0014);
    rd(4'h3, d); chk("R10 internal kept", d, 16'h0030);
    int_src = '0;
    ack(1'b1, oe, v, po); chk("R10 edge vec", {8'h0, v}, 16'h0015);
    rd(4'h3, d); chk("R10 edge cleared", d, 16'h0);
    chk("R4 irq idle", {15'b0, irq}, 16'h0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_cyc(100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule